// File: doc/BRIEF.md
# Text Cell Attribute Renderer

This block produces one 8-pixel slice of a character cell for a text display that is drawn as a bitmap. For each cell slice it takes the character code and the attribute byte read from video memory, the scanline inside the cell, the cell height, a running frame counter and a cursor-match flag. It builds the glyph memory address and looks up the glyph row. It then applies the attribute effects and returns the final pixels together with the cell's colour index.

The glyph memory is held inside the block as a computed pattern, so no content file is needed. Inputs arrive with a valid strobe. Results appear one clock later, marked by an output valid flag. While no valid input is present, the pixel and colour outputs keep their last values. The upstream fetch logic may present a new cell slice on every clock.

Top module: `text_attr_render`

## Requirements
- R1: The glyph address is the 13-bit value {row[4], code[7], row[3:0], code[6:0]}. The glyph byte stored at address A is A[7:0] XOR A[12:5]. With no effect active, the pixels equal that byte.
- R2: Attribute bit 4 (reverse) inverts every bit of the fetched glyph row.
- R3: Attribute bit 0 (underline) forces all ones on the scanline where row equals cell height minus 1.
- R4: Attribute bit 1 (overline) forces all ones on scanline 0.
- R5: Attribute bit 2 (vertical bar) forces pixel bit 3 to one on every scanline.
- R6: Attribute bit 3 (blink) forces all zeros while bit 4 of the frame counter is one, and has no effect while that bit is zero.
- R7: The cursor flag inverts the whole line while bit 4 of the frame counter is one, and has no effect while that bit is zero.
- R8: The effects apply in a fixed order: reverse, underline, overline, vertical bar, blink, cursor. Each later effect acts on the result of the earlier ones, so reverse with underline gives all ones, and blink with cursor in the blink phase also gives all ones.
- R9: A row value greater than or equal to the cell height gives all-zero pixels, whatever the attributes, the cursor flag or the frame counter. This includes a cell height of 0.
- R10: The colour output is attribute bits 7:5.
- R11: The outputs follow a valid input by exactly one clock. The output valid flag equals the input valid of the previous clock. While the input valid is low, the pixels and the colour hold their values.
- R12: During reset, the output valid flag, the pixels and the colour are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input cell slice is valid |
| char_code | input | 8 | Character code |
| attr | input | 8 | Attribute byte |
| row | input | 5 | Scanline inside the cell |
| cell_h | input | 5 | Cell height in scanlines |
| frame_cnt | input | 8 | Running frame counter |
| cursor_hit | input | 1 | Cursor address matches this cell |
| out_valid | output | 1 | Output slice is valid |
| pix | output | 8 | Rendered pixel line |
| color | output | 3 | Colour index |

## Verification
The plain-glyph patterns use codes with and without bit 7 and rows below and above 16. Any swap or misplacement of the split address bits therefore shows up as a different glyph byte. Each effect is tried alone on the first, a middle and the last scanline, in both frame-counter phases. This separates row-gated effects from unconditional ones and phase-gated effects from steady ones. Paired effects (reverse with underline, blink with cursor, reverse with vertical bar) expose any change in ordering. Rows at and beyond the cell height, and a zero height, confirm that the range gate overrides everything. A long pseudo-random stream, with idle cycles mixed in, checks latency and hold behaviour.

// File: rtl/ttr_pkg.sv
package ttr_pkg;
   // Attribute byte layout; bit positions are decoded by the effect chain.
   typedef struct packed {
      logic [2:0] color;
      logic       reverse;
      logic       blink;
      logic       vbar;
      logic       over;
      logic       under;
   } attr_t;
endpackage

// File: rtl/ttr_glyph_rom.sv
module ttr_glyph_rom #(
   parameter int CODE_W = 8,
   parameter int ROW_W  = 5,
   parameter int PIX_W  = 8
) (
   input  logic [CODE_W-1:0] code,
   input  logic [ROW_W-1:0]  row,
   output logic [PIX_W-1:0]  data
);
   localparam int ADDR_W = CODE_W + ROW_W;

   if (ADDR_W < PIX_W) begin : g_bad_addr
      $error("glyph address narrower than pixel word");
   end

   logic [ADDR_W-1:0] addr;

   // split address: high bits of code and row sit on top
   assign addr = {row[ROW_W-1], code[CODE_W-1], row[ROW_W-2:0], code[CODE_W-2:0]};

   // computed content stands in for a mask ROM
   assign data = addr[PIX_W-1:0] ^ addr[ADDR_W-1 -: PIX_W];
endmodule

// File: rtl/ttr_effects.sv
module ttr_effects
   import ttr_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int ROW_W    = 5,
   parameter int VBAR_BIT = 3
) (
   input  logic [PIX_W-1:0] glyph,
   input  attr_t            at,
   input  logic [ROW_W-1:0] row,
   input  logic [ROW_W-1:0] cell_h,
   input  logic             phase,
   input  logic             cursor,
   output logic [PIX_W-1:0] pix
);
   if (VBAR_BIT >= PIX_W) begin : g_bad_vbar
      $error("vertical bar position outside pixel word");
   end

   logic [ROW_W-1:0] last_row;
   logic             in_range, under_hit, over_hit, blank, invert;

   always_comb begin
      last_row  = cell_h - 1'b1;
      in_range  = row < cell_h;
      under_hit = at.under && (row == last_row);
      over_hit  = at.over && (row == '0);
      blank     = at.blink && phase;
      invert    = cursor && phase;
   end

   // one lane per pixel; effects chained in fixed order
   for (genvar i = 0; i < PIX_W; i++) begin : g_lane
      logic s_rev, s_ul, s_ol, s_vb, s_bl, s_cu;
      always_comb begin
         s_rev = glyph[i] ^ at.reverse;
         s_ul  = under_hit ? 1'b1 : s_rev;
         s_ol  = over_hit ? 1'b1 : s_ul;
         s_vb  = (at.vbar && (i == VBAR_BIT)) ? 1'b1 : s_ol;
         s_bl  = blank ? 1'b0 : s_vb;
         s_cu  = s_bl ^ invert;
      end
      assign pix[i] = in_range & s_cu;
   end
endmodule

// File: rtl/text_attr_render.sv
module text_attr_render
   import ttr_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int ROW_W     = 5,
   parameter int PIX_W     = 8,
   parameter int FRAME_W   = 8,
   parameter int BLINK_BIT = 4,
   parameter int VBAR_BIT  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [CODE_W-1:0]  char_code,
   input  logic [7:0]         attr,
   input  logic [ROW_W-1:0]   row,
   input  logic [ROW_W-1:0]   cell_h,
   input  logic [FRAME_W-1:0] frame_cnt,
   input  logic               cursor_hit,
   output logic               out_valid,
   output logic [PIX_W-1:0]   pix,
   output logic [2:0]         color
);
   localparam int COLOR_W = $bits(attr_t) - 5;

   if (BLINK_BIT >= FRAME_W) begin : g_bad_blink
      $error("blink phase bit outside frame counter");
   end
   if (ROW_W < 2 || CODE_W < 2) begin : g_bad_w
      $error("code and row need at least two bits");
   end

   attr_t            at;
   logic [PIX_W-1:0] glyph, pix_c;

   assign at = attr_t'(attr);

   ttr_glyph_rom #(.CODE_W(CODE_W), .ROW_W(ROW_W), .PIX_W(PIX_W)) u_rom (
      .code (char_code),
      .row  (row),
      .data (glyph)
   );

   ttr_effects #(.PIX_W(PIX_W), .ROW_W(ROW_W), .VBAR_BIT(VBAR_BIT)) u_fx (
      .glyph  (glyph),
      .at     (at),
      .row    (row),
      .cell_h (cell_h),
      .phase  (frame_cnt[BLINK_BIT]),
      .cursor (cursor_hit),
      .pix    (pix_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pix       <= '0;
         color     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pix   <= pix_c;
            color <= at.color[COLOR_W-1:0];
         end
      end
   end
endmodule

// File: rtl/text_attr_render_chk.sv
module text_attr_render_chk #(
   parameter int CODE_W    = 8,
   parameter int ROW_W     = 5,
   parameter int PIX_W     = 8,
   parameter int FRAME_W   = 8,
   parameter int BLINK_BIT = 4,
   parameter int VBAR_BIT  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [CODE_W-1:0]  char_code,
   input logic [7:0]         attr,
   input logic [ROW_W-1:0]   row,
   input logic [ROW_W-1:0]   cell_h,
   input logic [FRAME_W-1:0] frame_cnt,
   input logic               cursor_hit,
   input logic               out_valid,
   input logic [PIX_W-1:0]   pix,
   input logic [2:0]         color
);
   // R11
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(pix) && $stable(color)));
   // R9
   range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && row >= cell_h) |=> (pix == '0));
   // R10
   color_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (color == $past(attr[7:5])));
   // R6
   blink_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && attr[3] && frame_cnt[BLINK_BIT] && !cursor_hit) |=> (pix == '0));
   // R5
   vbar_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && attr[2] && !frame_cnt[BLINK_BIT] && row < cell_h) |=> pix[VBAR_BIT]);
   // R8
   blink_cursor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && attr[3] && cursor_hit && frame_cnt[BLINK_BIT] && row < cell_h)
      |=> (pix == '1));
endmodule

bind text_attr_render text_attr_render_chk #(
   .CODE_W(CODE_W), .ROW_W(ROW_W), .PIX_W(PIX_W),
   .FRAME_W(FRAME_W), .BLINK_BIT(BLINK_BIT), .VBAR_BIT(VBAR_BIT)
) u_chk (.*);

// File: tb/tb_text_attr_render.sv
module tb_text_attr_render;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] char_code = '0;
   logic [7:0] attr = '0;
   logic [4:0] row = '0;
   logic [4:0] cell_h = '0;
   logic [7:0] frame_cnt = '0;
   logic       cursor_hit = 1'b0;
   logic       out_valid;
   logic [7:0] pix;
   logic [2:0] color;

   int vectors = 0;
   int misses = 0;
   bit done = 0;

   int    e_valid = 0, e_pix = 0, e_col = 0;
   bit    pending = 0;
   string e_tag = "";

   always #5 clk = ~clk;

   text_attr_render dut (.*);

   function automatic int ref_pix(int c, int a, int r, int h, int f, int cur);
      int ad, g;
      if (r >= h) return 0;
      ad = (((r >> 4) & 1) << 12) + (((c >> 7) & 1) << 11) + ((r & 15) << 7) + (c & 127);
      g = (ad ^ (ad >> 5)) & 255;
      if (a & 16) g = g ^ 255;
      if ((a & 1) && r == h - 1) g = 255;
      if ((a & 2) && r == 0) g = 255;
      if (a & 4) g = g | 8;
      if ((a & 8) && (f & 16)) g = 0;
      if (cur && (f & 16)) g = g ^ 255;
      return g;
   endfunction

   task automatic compare();
      if (!pending) return;
      vectors++;
      if (out_valid !== e_valid[0] || pix !== e_pix[7:0] || color !== e_col[2:0]) begin
         misses++;
         $display("FAIL %s: valid/pix/color got %0b/%02h/%0d expected %0b/%02h/%0d",
                  e_tag, out_valid, pix, color, e_valid[0], e_pix[7:0], e_col[2:0]);
      end
   endtask

   task automatic step(input bit v, input int c, input int a, input int r, input int h,
                       input int f, input bit cur, input string tag);
      @(negedge clk);
      compare();
      in_valid = v; char_code = c[7:0]; attr = a[7:0]; row = r[4:0];
      cell_h = h[4:0]; frame_cnt = f[7:0]; cursor_hit = cur;
      e_valid = v;
      if (v) begin
         e_pix = ref_pix(c, a, r, h, f, cur);
         e_col = (a >> 5) & 7;
      end
      e_tag = tag;
      pending = 1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         misses++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      int codes[6] = '{8'h00, 8'h41, 8'h7f, 8'h80, 8'hc3, 8'hff};
      int rows[5]  = '{0, 5, 15, 16, 30};
      int lfsr = 32'h1ace;
      // R12 reset state
      in_valid = 1'b1; attr = 8'hff;
      repeat (3) begin
         @(negedge clk);
         vectors++;
         if (out_valid !== 1'b0 || pix !== 8'h00 || color !== 3'd0) begin
            misses++;
            $display("FAIL R12: got %0b/%02h/%0d expected 0/00/0", out_valid, pix, color);
         end
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      // R1 plain glyph address and content
      foreach (codes[i])
         foreach (rows[j])
            step(1, codes[i], 0, rows[j], 31, 0, 0, "R1");
      // R10 colour
      for (int k = 0; k < 8; k++) step(1, 8'h55 + k, k << 5, 3, 12, 0, 0, "R10");
      // single effects, rows first/middle/last, both phases
      for (int ph = 0; ph < 2; ph++) begin
         for (int r = 0; r < 12; r += 5) begin
            step(1, 8'h9a, 8'h10, r, 11, ph * 16, 0, "R2");
            step(1, 8'h9a, 8'h01, r, 11, ph * 16, 0, "R3");
            step(1, 8'h9a, 8'h02, r, 11, ph * 16, 0, "R4");
            step(1, 8'h9a, 8'h04, r, 11, ph * 16, 0, "R5");
            step(1, 8'h9a, 8'h08, r, 11, ph * 16 + 3, 0, "R6");
            step(1, 8'h9a, 8'h00, r, 11, ph * 16 + 7, 1, "R7");
         end
      end
      // R8 ordering combinations
      step(1, 8'h21, 8'h11, 10, 11, 0, 0, "R8");
      step(1, 8'h21, 8'h12, 0, 11, 0, 0, "R8");
      step(1, 8'h21, 8'h14, 4, 11, 0, 0, "R8");
      step(1, 8'h21, 8'h08, 4, 11, 16, 1, "R8");
      step(1, 8'h21, 8'h1f, 10, 11, 16, 1, "R8");
      step(1, 8'h21, 8'h07, 0, 1, 0, 0, "R8");
      // R9 out of range rows
      step(1, 8'h33, 8'hf7, 11, 11, 0, 0, "R9");
      step(1, 8'h33, 8'hff, 20, 11, 16, 1, "R9");
      step(1, 8'h33, 8'h17, 0, 0, 0, 1, "R9");
      step(1, 8'h33, 8'h17, 31, 0, 16, 1, "R9");
      // R11 idle hold
      step(1, 8'h44, 8'ha0, 2, 8, 0, 0, "R11");
      step(0, 8'h00, 8'h1f, 0, 8, 16, 1, "R11");
      step(0, 8'hff, 8'h00, 7, 8, 0, 0, "R11");
      step(1, 8'h45, 8'h40, 7, 8, 0, 0, "R11");
      // R8 mixed stream with idle gaps
      for (int n = 0; n < 400; n++) begin
         lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
         step((lfsr & 7) != 0, (lfsr >> 3) & 255, (lfsr >> 11) & 255, (lfsr >> 19) & 31,
              ((lfsr >> 24) & 31) | 1, (lfsr >> 6) & 255, (lfsr >> 29) & 1, "R8");
      end
      @(negedge clk);
      compare();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule